// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours (24-hour), day of week, date, month, two-digit year and a century above the year. A one-cycle enable pulse at the slow oscillator rate (nominally 32.768 kHz) feeds a prescaler. Each time the prescaler wraps, the time advances by one second. The rollover handles month lengths, February in leap years, the year and the century.

Two copies of the time exist. The internal copy always counts while the run bit is set. The host-visible copy follows the internal one unless the host sets the freeze bit. While frozen, the host reads a steady snapshot and may write new field values into it. When the host clears freeze after such writes, the whole visible copy is loaded into the internal copy and the prescaler restarts, so the new time begins a full second later. The run bit sits in bit 7 of the month register.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the registers read: seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x81 (run bit 7 set, month 01), year 0x00, century 0x20, control 0x00.
- R2: While running, the seconds advance exactly once per TICKS_PER_SEC oscillator pulses. Seconds and minutes count 00..59 in BCD, and 59 wraps to 00 with a carry into the next field.
- R3: Hours count 00..23 in BCD. After 23:59:59 the next second reads 00:00:00 and the date advances.
- R4: Day of week counts 1..7. It steps at each midnight, separately from the date, and 7 wraps to 1.
- R5: After the last day of a month the date reads 01 and the month advances. Months 04, 06, 09 and 11 end on day 30, and the others (February aside) end on day 31.
- R6: February ends on day 29 when the BCD year is divisible by four (including 00), and on day 28 otherwise.
- R7: After December 31 at 23:59:59 the result is January 01 and the year increments. Year 99 wraps to 00 with the century incremented, and century 99 wraps to 00.
- R8: With the run bit (month bit 7) cleared, oscillator pulses have no effect on the time or the prescaler. Setting the bit again resumes counting.
- R9: Control register (address 8) bit 0 set freezes the visible copy, while the internal copy keeps counting. Clearing it without any field write in between makes the visible copy show the advanced internal time.
- R10: A field write while frozen changes only the visible copy, and it can be read back at once. On unfreeze, the entire visible copy is loaded into the internal copy and the prescaler is cleared.
- R11: A field write while not frozen loads the internal field directly, is readable on the next cycle and clears the prescaler.
- R12: Address map: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month/run, 6 year, 7 century, 8 control. Addresses 9..15 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| addr | input | 4 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, registered at the clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register (visible copy) |

## Verification
Rollover is tried from 23:59:59 under several dates. A mid-month date isolates the hour and day-of-week carry. The ends of 30-day and 31-day months separate the month-length table. February 28 and 29 in years 00, 10, 12, 23 and 24 separate true divisibility by four from a test on the low BCD digit. December 31 in years 24 and 99, and century 99, show each carry stage in turn. Pulse counts just short of and just at a full second show the prescaler period, and show that the prescaler clears after a direct write, a run-bit write and a frozen-load. Frozen reads taken during elapsed seconds, compared with the reads after unfreeze with and without prior writes, tell the snapshot, resync and load paths apart.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam logic [3:0] A_SEC  = 4'd0;
    localparam logic [3:0] A_MIN  = 4'd1;
    localparam logic [3:0] A_HOUR = 4'd2;
    localparam logic [3:0] A_DOW  = 4'd3;
    localparam logic [3:0] A_DATE = 4'd4;
    localparam logic [3:0] A_MON  = 4'd5;
    localparam logic [3:0] A_YEAR = 4'd6;
    localparam logic [3:0] A_CENT = 4'd7;
    localparam logic [3:0] A_CTRL = 4'd8;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic       run;
        logic [4:0] month;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } cal_time_t;

    localparam cal_time_t TIME_RESET = '{
        cent: 8'h20, year: 8'h00, run: 1'b1, month: 5'h01,
        date: 6'h01, dow: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00
    };

    // Packed BCD increment of a two-digit value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Divisible by four for a BCD year: even tens need 0/4/8, odd tens need 2/6.
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic cal_time_t put_field(input cal_time_t t, input logic [3:0] a,
                                            input logic [7:0] d);
        cal_time_t r;
        r = t;
        case (a)
            A_SEC:   r.sec   = d[6:0];
            A_MIN:   r.min   = d[6:0];
            A_HOUR:  r.hour  = d[5:0];
            A_DOW:   r.dow   = d[2:0];
            A_DATE:  r.date  = d[5:0];
            A_MON:   begin r.run = d[7]; r.month = d[4:0]; end
            A_YEAR:  r.year  = d;
            A_CENT:  r.cent  = d;
            default: r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic run,
    input  logic clear,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        sec_pulse = run && osc_tick && (cnt_q == LAST);
        cnt_d     = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && osc_tick) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: the count never passes the divisor
    p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8: a stopped prescaler does not move unless cleared
    p_stopped_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import cal_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    logic [7:0] sec_i, min_i, hour_i, date_i, mon_i, year_i, cent_i;
    logic [5:0] last_day;

    always_comb begin
        sec_i    = bcd_inc({1'b0, cur.sec});
        min_i    = bcd_inc({1'b0, cur.min});
        hour_i   = bcd_inc({2'b0, cur.hour});
        date_i   = bcd_inc({2'b0, cur.date});
        mon_i    = bcd_inc({3'b0, cur.month});
        year_i   = bcd_inc(cur.year);
        cent_i   = bcd_inc(cur.cent);
        last_day = month_last(cur.month, cur.year);

        nxt = cur;
        if (cur.sec != 7'h59) begin
            nxt.sec = sec_i[6:0];
        end else begin
            nxt.sec = 7'h00;
            if (cur.min != 7'h59) begin
                nxt.min = min_i[6:0];
            end else begin
                nxt.min = 7'h00;
                if (cur.hour != 6'h23) begin
                    nxt.hour = hour_i[5:0];
                end else begin
                    nxt.hour = 6'h00;
                    nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
                    if (cur.date != last_day) begin
                        nxt.date = date_i[5:0];
                    end else begin
                        nxt.date = 6'h01;
                        if (cur.month != 5'h12) begin
                            nxt.month = mon_i[4:0];
                        end else begin
                            nxt.month = 5'h01;
                            if (cur.year != 8'h99) begin
                                nxt.year = year_i;
                            end else begin
                                nxt.year = 8'h00;
                                nxt.cent = (cur.cent == 8'h99) ? 8'h00 : cent_i;
                            end
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cal_host_regs.sv
module cal_host_regs
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_pulse,
    input  cal_time_t  adv,
    input  logic [3:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output cal_time_t  int_time,
    output logic       presc_clear,
    output logic [7:0] rd_data
);
    typedef struct packed {
        cal_time_t int_t;
        cal_time_t ext_t;
        logic      freeze;
        logic      dirty;
    } regs_t;

    regs_t st_d, st_q;
    logic  time_wr, ctl_wr;

    assign time_wr = wr_en && (addr <= A_CENT);
    assign ctl_wr  = wr_en && (addr == A_CTRL);

    // Prescaler restarts on a direct load or on a load from the frozen copy.
    assign presc_clear = (time_wr && !st_q.freeze) ||
                         (ctl_wr && !wr_data[0] && st_q.freeze && st_q.dirty);

    always_comb begin
        st_d = st_q;
        if (sec_pulse) st_d.int_t = adv;
        if (!st_q.freeze) begin
            if (time_wr) st_d.int_t = put_field(st_q.int_t, addr, wr_data);
            if (ctl_wr && wr_data[0]) begin
                st_d.freeze = 1'b1;
                st_d.dirty  = 1'b0;
            end
            st_d.ext_t = st_d.int_t;
        end else begin
            if (time_wr) begin
                st_d.ext_t = put_field(st_q.ext_t, addr, wr_data);
                st_d.dirty = 1'b1;
            end
            if (ctl_wr && !wr_data[0]) begin
                st_d.freeze = 1'b0;
                st_d.dirty  = 1'b0;
                if (st_q.dirty) st_d.int_t = st_q.ext_t;
                st_d.ext_t = st_d.int_t;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.int_t  <= TIME_RESET;
            st_q.ext_t  <= TIME_RESET;
            st_q.freeze <= 1'b0;
            st_q.dirty  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_time = st_q.int_t;

    always_comb begin
        case (addr)
            A_SEC:   rd_data = {1'b0, st_q.ext_t.sec};
            A_MIN:   rd_data = {1'b0, st_q.ext_t.min};
            A_HOUR:  rd_data = {2'b0, st_q.ext_t.hour};
            A_DOW:   rd_data = {5'b0, st_q.ext_t.dow};
            A_DATE:  rd_data = {2'b0, st_q.ext_t.date};
            A_MON:   rd_data = {st_q.ext_t.run, 2'b0, st_q.ext_t.month};
            A_YEAR:  rd_data = st_q.ext_t.year;
            A_CENT:  rd_data = st_q.ext_t.cent;
            A_CTRL:  rd_data = {7'b0, st_q.freeze};
            default: rd_data = 8'h00;
        endcase
    end

    // R9: a frozen visible copy holds while the host does not write
    p_frozen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.freeze && !wr_en) |=> $stable(st_q.ext_t));

    // R9: the internal copy keeps counting while frozen
    p_counts_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.freeze && sec_pulse && !wr_en) |=> (st_q.int_t != $past(st_q.int_t)));

    // R11: unfrozen, both copies agree
    p_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.freeze |-> (st_q.ext_t == st_q.int_t));

    // R10: unfreeze after writes loads the visible copy into the internal copy
    p_unfreeze_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.freeze && st_q.dirty && ctl_wr && !wr_data[0])
        |=> (st_q.int_t == $past(st_q.ext_t)));

    // R3: hours stay within the 24-hour range
    p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.int_t.hour <= 6'h23);

    // R4: day of week never reads zero
    p_dow_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.int_t.dow != 3'd0);

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic [3:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    cal_time_t int_time, adv_time;
    logic      sec_pulse, presc_clear;

    cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .run       (int_time.run),
        .clear     (presc_clear),
        .sec_pulse (sec_pulse)
    );

    cal_advance u_adv (
        .cur (int_time),
        .nxt (adv_time)
    );

    cal_host_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_pulse   (sec_pulse),
        .adv         (adv_time),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .int_time    (int_time),
        .presc_clear (presc_clear),
        .rd_data     (rd_data)
    );

endmodule

// File: tb/tb_bcd_calendar_clock.sv
module tb_bcd_calendar_clock;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [3:0] addr = 4'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [3:0] a;
        string      tag;
    } exp_item_t;
    exp_item_t sb[$];

    always #4 clk = ~clk;

    bcd_calendar_clock #(.TICKS_PER_SEC(TPS)) dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    // Monitor: compares every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_item_t it;
            it = sb.pop_front();
            checks++;
            if (rd_data !== it.exp) begin
                errors++;
                $display("FAIL %s addr %0d: actual %h expected %h", it.tag, it.a, rd_data, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_item_t it;
        @(posedge clk); #1;
        addr = a;
        it.exp = e; it.a = a; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; osc_tick = 1'b1;
            @(posedge clk); #1; osc_tick = 1'b0;
        end
    endtask

    task automatic secs(input int n);
        tick(n * TPS);
    endtask

    task automatic set_time(input logic [7:0] ce, input logic [7:0] yr, input logic [7:0] mo,
                            input logic [7:0] dt, input logic [7:0] dw, input logic [7:0] hr,
                            input logic [7:0] mi, input logic [7:0] se);
        wr(4'd8, 8'h01);
        wr(4'd0, se); wr(4'd1, mi); wr(4'd2, hr); wr(4'd3, dw);
        wr(4'd4, dt); wr(4'd5, 8'h80 | mo); wr(4'd6, yr); wr(4'd7, ce);
        wr(4'd8, 8'h00);
    endtask

    // Set the given date at 23:59:59, step one second, check date and month.
    task automatic day_roll(input logic [7:0] ce, input logic [7:0] yr, input logic [7:0] mo,
                            input logic [7:0] dt, input logic [7:0] exp_dt,
                            input logic [7:0] exp_mo, input string tag);
        set_time(ce, yr, mo, dt, 8'h02, 8'h23, 8'h59, 8'h59);
        secs(1);
        chk(4'd4, exp_dt, tag);
        chk(4'd5, exp_mo, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(4'd0, 8'h00, "R1 sec");
        chk(4'd1, 8'h00, "R1 min");
        chk(4'd2, 8'h00, "R1 hour");
        chk(4'd3, 8'h01, "R1 dow");
        chk(4'd4, 8'h01, "R1 date");
        chk(4'd5, 8'h81, "R1 month");
        chk(4'd6, 8'h00, "R1 year");
        chk(4'd7, 8'h20, "R1 cent");
        chk(4'd8, 8'h00, "R1 ctrl");
        chk(4'd15, 8'h00, "R12 unused read");

        // R2 prescaler period and seconds/minutes wrap
        tick(TPS - 1);
        chk(4'd0, 8'h00, "R2 before full second");
        tick(1);
        chk(4'd0, 8'h01, "R2 at full second");
        set_time(8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h58);
        secs(1);
        chk(4'd0, 8'h59, "R2 sec 59");
        secs(1);
        chk(4'd0, 8'h00, "R2 sec wrap");
        chk(4'd1, 8'h01, "R2 min carry");

        // R3 midnight, R4 day of week
        set_time(8'h20, 8'h24, 8'h03, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59);
        secs(1);
        chk(4'd2, 8'h00, "R3 hour wrap");
        chk(4'd1, 8'h00, "R3 min wrap");
        chk(4'd4, 8'h16, "R3 date step");
        chk(4'd3, 8'h04, "R4 dow step");
        set_time(8'h20, 8'h24, 8'h03, 8'h16, 8'h07, 8'h23, 8'h59, 8'h59);
        secs(1);
        chk(4'd3, 8'h01, "R4 dow wrap 7 to 1");
        chk(4'd4, 8'h17, "R4 date independent");

        // R5 month lengths
        day_roll(8'h20, 8'h24, 8'h04, 8'h30, 8'h01, 8'h85, "R5 april 30");
        day_roll(8'h20, 8'h24, 8'h06, 8'h29, 8'h30, 8'h86, "R5 june 29");
        day_roll(8'h20, 8'h24, 8'h01, 8'h31, 8'h01, 8'h82, "R5 january 31");
        day_roll(8'h20, 8'h24, 8'h11, 8'h30, 8'h01, 8'h92, "R5 november 30");

        // R6 February
        day_roll(8'h20, 8'h24, 8'h02, 8'h28, 8'h29, 8'h82, "R6 feb 28 leap 24");
        day_roll(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h83, "R6 feb 29 leap 24");
        day_roll(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h83, "R6 feb 28 year 23");
        day_roll(8'h20, 8'h00, 8'h02, 8'h28, 8'h29, 8'h82, "R6 feb 28 year 00");
        day_roll(8'h20, 8'h10, 8'h02, 8'h28, 8'h01, 8'h83, "R6 feb 28 year 10");
        day_roll(8'h20, 8'h12, 8'h02, 8'h28, 8'h29, 8'h82, "R6 feb 28 year 12");

        // R7 year and century
        day_roll(8'h20, 8'h24, 8'h12, 8'h31, 8'h01, 8'h81, "R7 dec 31");
        chk(4'd6, 8'h25, "R7 year step");
        day_roll(8'h20, 8'h99, 8'h12, 8'h31, 8'h01, 8'h81, "R7 dec 31 year 99");
        chk(4'd6, 8'h00, "R7 year wrap");
        chk(4'd7, 8'h21, "R7 century step");
        chk(4'd2, 8'h00, "R7 hour");
        chk(4'd0, 8'h00, "R7 sec");
        day_roll(8'h99, 8'h99, 8'h12, 8'h31, 8'h01, 8'h81, "R7 century 99");
        chk(4'd7, 8'h00, "R7 century wrap");

        // R8 run bit
        set_time(8'h20, 8'h24, 8'h05, 8'h10, 8'h05, 8'h12, 8'h00, 8'h00);
        wr(4'd5, 8'h05);
        tick(3 * TPS);
        chk(4'd0, 8'h00, "R8 stopped sec");
        chk(4'd5, 8'h05, "R8 stopped month");
        wr(4'd5, 8'h85);
        tick(TPS);
        chk(4'd0, 8'h01, "R8 resumed");

        // R9 freeze and resync
        wr(4'd8, 8'h01);
        chk(4'd8, 8'h01, "R9 ctrl frozen");
        tick(3 * TPS);
        chk(4'd0, 8'h01, "R9 frozen snapshot");
        wr(4'd8, 8'h00);
        chk(4'd0, 8'h04, "R9 resync after freeze");

        // R10 frozen write and load
        wr(4'd8, 8'h01);
        wr(4'd1, 8'h30);
        chk(4'd1, 8'h30, "R10 frozen write readback");
        tick(2 * TPS);
        chk(4'd0, 8'h04, "R10 frozen sec held");
        wr(4'd8, 8'h00);
        chk(4'd1, 8'h30, "R10 loaded min");
        chk(4'd0, 8'h04, "R10 loaded sec");
        chk(4'd2, 8'h12, "R10 loaded hour");
        tick(TPS - 1);
        chk(4'd0, 8'h04, "R10 prescaler cleared");
        tick(1);
        chk(4'd0, 8'h05, "R10 next second");

        // R11 direct write
        tick(2);
        wr(4'd0, 8'h45);
        chk(4'd0, 8'h45, "R11 direct write");
        tick(TPS - 1);
        chk(4'd0, 8'h45, "R11 prescaler cleared");
        tick(1);
        chk(4'd0, 8'h46, "R11 next second");

        // R12 unused addresses
        wr(4'd12, 8'hFF);
        wr(4'd9, 8'h7F);
        chk(4'd12, 8'h00, "R12 unused write ignored");
        chk(4'd0, 8'h46, "R12 sec untouched");
        chk(4'd1, 8'h30, "R12 min untouched");
        chk(4'd4, 8'h10, "R12 date untouched");
        chk(4'd8, 8'h00, "R12 ctrl untouched");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule